// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer with Compare and Output Pin

This block is a free-running up-counter timer with a word-wide register port. Software starts and stops it, picks an optional power-of-two prescale, and chooses whether the counter reloads from a load register or stops when it wraps past its maximum. A match register, compared against the running count, supplies a second event source. Overflow and match events can toggle the timer pin or emit a one-clock pulse on it. They also feed a small interrupt block with three sources. That block has an interrupt mask, a write-one-to-clear status, a level interrupt line and a separately masked one-clock wakeup pulse.

The third interrupt source, capture, comes in as a one-clock event from a capture unit outside this block. Register reads are registered: the read data for the offset on `addr` appears one clock later. Writes take effect at the clock edge where `wr_en` is high.

Top module: `gp_up_timer`

## Requirements
- R1: Register offsets: 0x00 identity (reads 0x21, writes ignored), 0x18 status, 0x1C interrupt enable, 0x20 wakeup enable, 0x24 control, 0x28 counter, 0x2C load, 0x30 trigger-reload, 0x38 match. `rd_data` shows the register at the previous cycle's `addr`. Unmapped offsets read 0 and ignore writes. The enable and status registers keep 3 bits.
- R2: The control register keeps bits 14:0 and reads back as written, with bits 31:15 reading 0. Bit 0 is run, bit 1 auto-reload, bits 4:2 prescale value, bit 5 prescale enable, bit 6 compare enable, bit 7 idle pin level, bits 9:8 capture mode (stored only), bits 11:10 trigger mode, bit 12 toggle select, bit 13 second-capture select (stored only), and bit 14 pin direction (1 = input).
- R3: With prescale enabled, the counter advances once every 2^(value+1) clocks while running. With prescale disabled it advances on every running clock.
- R4: A step from 0xFFFFFFFF is an overflow. With auto-reload set, the counter takes the load value and keeps running. With auto-reload clear, it becomes 0 and the run bit clears.
- R5: With compare enabled, a match event fires on the step whose new counter value equals the match register.
- R6: Trigger mode 0 gives no pin events. Mode 1 gives overflow events only, and modes 2 and 3 give overflow and match events. In toggle mode each event inverts the pin. Otherwise the pin shows the inverse of the idle level for the one clock after an event.
- R7: While stopped or in trigger mode 0, the pin returns to the idle level one clock later. `tmr_oe` is high exactly when the direction bit is 0.
- R8: Status bits are 0 match, 1 overflow and 2 capture. A bit is set by its event only if its interrupt-enable bit is set. Writing 1 clears a bit, and a same-cycle event wins. `irq_o` is high exactly while a status bit is set.
- R9: Each event whose wakeup-enable bit is set produces a one-clock `wake_o` pulse, whatever the interrupt mask.
- R10: Any write to the trigger-reload offset copies the load register into the counter. That offset reads 0xFFFFFFFF.
- R11: A counter write sets the counter at that edge, suppresses that cycle's step, and restarts the prescale phase. A match and an overflow in the same step set both status bits.
- R12: A `cap_evt` pulse is the capture event and sets status bit 2 and/or a wakeup pulse under the same masks.
- R13: While the run bit is 0, the counter holds its value unless written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| cap_evt | input | 1 | One-clock capture event from the capture unit |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | One-clock wakeup pulse |
| tmr_out | output | 1 | Timer pin value |
| tmr_oe | output | 1 | Timer pin output enable |

## Verification
Every cycle, the assertions check these rules:
- the identity read;
- the counter holding while stopped;
- the halt-and-clear on overflow without reload;
- the idle pin level;
- the interrupt line tracking status;
- status bits only rising when enabled;
- wakeups only with a set wakeup mask;
- counter and trigger-reload write effects.

The prescale period, the toggle and pulse shapes, the reload value after a wrap and the coincident match-plus-overflow case need the bench's behavioural model. That model is compared with all outputs on every clock across scripted scenarios.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NSRC   = 3;

  localparam logic [ADDR_W-1:0] OFF_ID   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STS  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_WEN  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_LOAD = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_TRG  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_MAT  = 8'h38;

  localparam logic [DATA_W-1:0] ID_VALUE = 32'h0000_0021;

  // event index inside the source vector
  localparam int EV_MAT = 0;
  localparam int EV_OVF = 1;
  localparam int EV_CAP = 2;

  typedef struct packed {
    logic       in_dir;
    logic       cap_second;
    logic       toggle;
    logic [1:0] trig;
    logic [1:0] cap_mode;
    logic       idle_lvl;
    logic       cmp_en;
    logic       psc_en;
    logic [2:0] psc_val;
    logic       reload;
    logic       run;
  } gpt_ctrl_t;

  localparam int CTRL_W = $bits(gpt_ctrl_t);
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             psc_en,
  input  logic [SEL_W-1:0] psc_val,
  input  logic             phase_clr,
  output logic             tick
);
  localparam int PH_W = 1 << SEL_W;

  logic [PH_W-1:0] ph_q;
  logic [PH_W:0]   term;

  always_comb begin
    term = ({{PH_W{1'b0}}, 1'b1} << (32'(psc_val) + 32'd1)) - 1'b1;
    tick = run && (!psc_en || ({1'b0, ph_q} >= term));
  end

  always_ff @(posedge clk) begin
    if (rst || !run || phase_clr) ph_q <= '0;
    else if (tick)                ph_q <= '0;
    else                          ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             wr_cnt,
  input  logic             wr_trg,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             mat_evt,
  output logic             halt_req
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             step, at_top;

  always_comb begin
    step   = tick && !wr_cnt && !wr_trg;
    at_top = &cnt_q;
    if (wr_cnt)      cnt_nxt = wr_val;
    else if (wr_trg) cnt_nxt = load_val;
    else if (step)   cnt_nxt = at_top ? (reload_en ? load_val : '0) : cnt_q + 1'b1;
    else             cnt_nxt = cnt_q;
    ovf_evt  = step && at_top;
    mat_evt  = step && cmp_en && (cnt_nxt == match_val);
    halt_req = ovf_evt && !reload_en;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] ien,
  input  logic [NSRC-1:0] wen,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] sts,
  output logic            irq,
  output logic            wake
);
  logic [NSRC-1:0] sts_q, sts_nxt;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb
      sts_nxt[i] = (sts_q[i] && !(clr_we && clr_bits[i])) || (evt[i] && ien[i]);

    always_ff @(posedge clk) begin
      if (rst) sts_q[i] <= 1'b0;
      else     sts_q[i] <= sts_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq  <= |sts_nxt;
      wake <= |(evt & wen);
    end
  end

  assign sts = sts_q;
endmodule

// File: rtl/gpt_pin.sv
module gpt_pin (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] trig,
  input  logic       toggle,
  input  logic       idle_lvl,
  input  logic       ovf_evt,
  input  logic       mat_evt,
  output logic       pin
);
  logic fire, idle;

  always_comb begin
    idle = !run || (trig == 2'd0);
    fire = ovf_evt || (trig[1] && mat_evt);
  end

  always_ff @(posedge clk) begin
    if (rst)         pin <= 1'b0;
    else if (idle)   pin <= idle_lvl;
    else if (toggle) pin <= fire ? !pin : pin;
    else             pin <= fire ? !idle_lvl : idle_lvl;
  end
endmodule

// File: rtl/gp_up_timer.sv
module gp_up_timer
  import gpt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cap_evt,
  output logic          irq_o,
  output logic          wake_o,
  output logic          tmr_out,
  output logic          tmr_oe
);
  gpt_ctrl_t       ctrl_q;
  logic [NSRC-1:0] ien_q, wen_q, sts_w, evt_w;
  logic [DW-1:0]   load_q, match_q, cnt_w;
  logic            tick, ovf_evt, mat_evt, halt_req;
  logic            wr_cnt, wr_trg, wr_ctrl, wr_sts;

  always_comb begin
    wr_cnt  = wr_en && (addr == AW'(OFF_CNT));
    wr_trg  = wr_en && (addr == AW'(OFF_TRG));
    wr_ctrl = wr_en && (addr == AW'(OFF_CTRL));
    wr_sts  = wr_en && (addr == AW'(OFF_STS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (wr_ctrl)       ctrl_q     <= gpt_ctrl_t'(wr_data[CTRL_W-1:0]);
      else if (halt_req) ctrl_q.run <= 1'b0;
      if (wr_en && addr == AW'(OFF_IEN))  ien_q   <= wr_data[NSRC-1:0];
      if (wr_en && addr == AW'(OFF_WEN))  wen_q   <= wr_data[NSRC-1:0];
      if (wr_en && addr == AW'(OFF_LOAD)) load_q  <= wr_data;
      if (wr_en && addr == AW'(OFF_MAT))  match_q <= wr_data;
    end
  end

  gpt_prescaler #(.SEL_W(3)) u_psc (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .psc_en(ctrl_q.psc_en),
    .psc_val(ctrl_q.psc_val), .phase_clr(wr_cnt || wr_trg), .tick(tick)
  );

  gpt_counter #(.CNT_W(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .reload_en(ctrl_q.reload),
    .cmp_en(ctrl_q.cmp_en), .load_val(load_q), .match_val(match_q),
    .wr_cnt(wr_cnt), .wr_trg(wr_trg), .wr_val(wr_data), .cnt(cnt_w),
    .ovf_evt(ovf_evt), .mat_evt(mat_evt), .halt_req(halt_req)
  );

  always_comb begin
    evt_w         = '0;
    evt_w[EV_MAT] = mat_evt;
    evt_w[EV_OVF] = ovf_evt;
    evt_w[EV_CAP] = cap_evt;
  end

  gpt_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst), .evt(evt_w), .ien(ien_q), .wen(wen_q),
    .clr_we(wr_sts), .clr_bits(wr_data[NSRC-1:0]), .sts(sts_w),
    .irq(irq_o), .wake(wake_o)
  );

  gpt_pin u_pin (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .trig(ctrl_q.trig),
    .toggle(ctrl_q.toggle), .idle_lvl(ctrl_q.idle_lvl),
    .ovf_evt(ovf_evt), .mat_evt(mat_evt), .pin(tmr_out)
  );

  assign tmr_oe = !ctrl_q.in_dir;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (addr)
        AW'(OFF_ID):   rd_data <= ID_VALUE;
        AW'(OFF_STS):  rd_data <= DW'(sts_w);
        AW'(OFF_IEN):  rd_data <= DW'(ien_q);
        AW'(OFF_WEN):  rd_data <= DW'(wen_q);
        AW'(OFF_CTRL): rd_data <= DW'(ctrl_q);
        AW'(OFF_CNT):  rd_data <= cnt_w;
        AW'(OFF_LOAD): rd_data <= load_q;
        AW'(OFF_TRG):  rd_data <= '1;
        AW'(OFF_MAT):  rd_data <= match_q;
        default:       rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  addr,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        irq_o,
  input logic        wake_o,
  input logic        tmr_out,
  input logic [14:0] ctrl,
  input logic [31:0] cnt,
  input logic [31:0] load,
  input logic [2:0]  sts,
  input logic [2:0]  ien,
  input logic [2:0]  wen,
  input logic        ovf
);
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h00) |=> (rd_data == 32'h21)); // R1
  AST_NOAR_HALT: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ctrl[1] && !wr_en) |=> (!ctrl[0] && cnt == 32'd0)); // R4
  AST_IDLE_PIN: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] || ctrl[11:10] == 2'd0) |=> (tmr_out == $past(ctrl[7]))); // R7
  AST_STS_GATED: assert property (@(posedge clk) disable iff (rst)
    ((sts & ~$past(sts) & ~$past(ien)) == 3'b000)); // R8
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq_o == (sts != 3'b000))); // R8
  AST_WAKE_SRC: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ($past(wen) != 3'b000)); // R9
  AST_TRG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h30) |=> (cnt == $past(load))); // R10
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h28) |=> (cnt == $past(wr_data))); // R11
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] && !wr_en) |=> $stable(cnt)); // R13
endmodule

bind gp_up_timer gpt_checker u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o), .tmr_out(tmr_out),
  .ctrl(ctrl_q), .cnt(cnt_w), .load(load_q), .sts(sts_w), .ien(ien_q),
  .wen(wen_q), .ovf(ovf_evt)
);

// File: tb/tb_gp_up_timer.sv
module tb_gp_up_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h28;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cap_evt = 1'b0;
  logic [31:0] rd_data;
  logic        irq_o, wake_o, tmr_out, tmr_oe;

  always #2 clk = !clk; // 250 MHz

  gp_up_timer dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cap_evt(cap_evt), .irq_o(irq_o), .wake_o(wake_o),
    .tmr_out(tmr_out), .tmr_oe(tmr_oe)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [14:0] m_ctrl;
  logic [31:0] m_cnt, m_load, m_match, m_rd;
  logic [2:0]  m_ien, m_wen, m_sts;
  logic        m_irq, m_wake, m_pin;
  int          m_ps;

  function automatic logic [31:0] cw(bit dir, bit tog, int trig, bit lvl, bit ce,
                                     bit pe, int pv, bit ar, bit st);
    return {17'b0, dir, 1'b0, tog, 2'(trig), 2'b00, lvl, ce, pe, 3'(pv), ar, st};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_cnt = '0; m_load = '0; m_match = '0; m_rd = '0;
      m_ien = '0; m_wen = '0; m_sts = '0; m_irq = 0; m_wake = 0; m_pin = 0; m_ps = 0;
    end else begin
      logic [14:0] nctrl;
      logic [31:0] ncnt;
      logic [2:0]  ev, clr;
      bit tick, ovf, mat, wc, wt, fire;
      int per;
      case (addr)
        8'h00: m_rd = 32'h21;
        8'h18: m_rd = {29'b0, m_sts};
        8'h1C: m_rd = {29'b0, m_ien};
        8'h20: m_rd = {29'b0, m_wen};
        8'h24: m_rd = {17'b0, m_ctrl};
        8'h28: m_rd = m_cnt;
        8'h2C: m_rd = m_load;
        8'h30: m_rd = 32'hFFFF_FFFF;
        8'h38: m_rd = m_match;
        default: m_rd = 32'h0;
      endcase
      wc = wr_en && addr == 8'h28;
      wt = wr_en && addr == 8'h30;
      per = m_ctrl[5] ? (1 << (int'(m_ctrl[4:2]) + 1)) : 1;
      tick = 0; ovf = 0; mat = 0;
      if (!m_ctrl[0] || wc || wt) m_ps = 0;
      else if (m_ps + 1 >= per) begin tick = 1; m_ps = 0; end
      else m_ps = m_ps + 1;
      nctrl = m_ctrl; ncnt = m_cnt;
      if (wc) ncnt = wr_data;
      else if (wt) ncnt = m_load;
      else if (tick) begin
        if (m_cnt == 32'hFFFF_FFFF) begin
          ovf = 1;
          if (m_ctrl[1]) ncnt = m_load;
          else begin ncnt = 0; nctrl[0] = 0; end
        end else ncnt = m_cnt + 1;
        mat = m_ctrl[6] && (ncnt == m_match);
      end
      ev = {cap_evt, ovf, mat};
      clr = (wr_en && addr == 8'h18) ? wr_data[2:0] : 3'b0;
      m_wake = |(ev & m_wen);
      fire = ovf || (m_ctrl[11] && mat);
      if (!m_ctrl[0] || m_ctrl[11:10] == 2'd0) m_pin = m_ctrl[7];
      else if (m_ctrl[12]) m_pin = fire ? !m_pin : m_pin;
      else m_pin = fire ? !m_ctrl[7] : m_ctrl[7];
      m_sts = (m_sts & ~clr) | (ev & m_ien);
      m_irq = |m_sts;
      if (wr_en) begin
        case (addr)
          8'h24: nctrl = wr_data[14:0];
          8'h1C: m_ien = wr_data[2:0];
          8'h20: m_wen = wr_data[2:0];
          8'h2C: m_load = wr_data;
          8'h38: m_match = wr_data;
          default: ;
        endcase
      end
      m_ctrl = nctrl; m_cnt = ncnt;
    end
  end

  task automatic cmp1(string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      cmp1("rd_data", rd_data, m_rd);
      cmp1("irq_o", {31'b0, irq_o}, {31'b0, m_irq});
      cmp1("wake_o", {31'b0, wake_o}, {31'b0, m_wake});
      cmp1("tmr_out", {31'b0, tmr_out}, {31'b0, m_pin});
      cmp1("tmr_oe", {31'b0, tmr_oe}, {31'b0, !m_ctrl[14]});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; addr = 8'h28;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); addr = a;
    @(negedge clk); addr = 8'h28;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, identity, unmapped offsets
    cur_req = "R1";
    addr = 8'h00; idle(3);
    rd(8'h24); rd(8'h18); rd(8'h04);
    wr(8'h00, 32'h55); rd(8'h00);
    wr(8'h04, 32'h1234); rd(8'h04);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C); // 3-bit keep
    // R10: trigger-reload offset reads all ones
    cur_req = "R10";
    rd(8'h30);
    // R2: control readback
    cur_req = "R2";
    wr(8'h24, 32'hFFFF_7F00); rd(8'h24);
    wr(8'h24, 32'h0); rd(8'h24);
    // R5 R6 R4: toggle, trigger mode 2, auto-reload
    cur_req = "R5";
    wr(8'h2C, 32'hFFFF_FFF0);
    wr(8'h38, 32'hFFFF_FFF8);
    wr(8'h28, 32'hFFFF_FFF0);
    cur_req = "R6";
    wr(8'h24, cw(0, 1, 2, 0, 1, 0, 0, 1, 1));
    cur_req = "R4";
    idle(40);
    // R8: write-one-to-clear
    cur_req = "R8";
    rd(8'h18);
    wr(8'h18, 32'h1); rd(8'h18);
    wr(8'h18, 32'h7); rd(8'h18);
    // R3 R4: prescale period 4, pulse mode, no reload
    cur_req = "R3";
    wr(8'h24, 32'h0);
    wr(8'h28, 32'hFFFF_FFF8);
    wr(8'h24, cw(0, 0, 1, 1, 1, 1, 1, 0, 1));
    idle(45);
    cur_req = "R4";
    rd(8'h24); idle(4);
    // R3: period 8
    cur_req = "R3";
    wr(8'h28, 32'hFFFF_FFF0);
    wr(8'h24, cw(0, 1, 2, 0, 1, 1, 2, 1, 1));
    idle(40);
    // R11: counter write mid-prescale restarts phase
    cur_req = "R11";
    idle(3); wr(8'h28, 32'h5); idle(20);
    wr(8'h24, 32'h0);
    // R9: wakeups without interrupt enable
    cur_req = "R9";
    wr(8'h18, 32'h7);
    wr(8'h1C, 32'h0); wr(8'h20, 32'h7);
    wr(8'h28, 32'hFFFF_FFF4);
    wr(8'h24, cw(0, 0, 2, 0, 1, 0, 0, 1, 1));
    idle(30); rd(8'h18);
    // R12: capture event
    cur_req = "R12";
    wr(8'h24, 32'h0);
    wr(8'h1C, 32'h4);
    @(negedge clk); cap_evt = 1'b1; @(negedge clk); cap_evt = 1'b0;
    rd(8'h18); idle(2);
    wr(8'h20, 32'h0);
    @(negedge clk); cap_evt = 1'b1; @(negedge clk); cap_evt = 1'b0;
    wr(8'h18, 32'h4); rd(8'h18);
    // R11: match and overflow in the same step
    cur_req = "R11";
    wr(8'h1C, 32'h7);
    wr(8'h2C, 32'h1000); wr(8'h38, 32'h1000);
    wr(8'h28, 32'hFFFF_FFFD);
    wr(8'h24, cw(0, 1, 3, 0, 1, 0, 0, 1, 1));
    idle(6); rd(8'h18);
    // R10: trigger-reload while running
    cur_req = "R10";
    wr(8'h30, 32'h0); idle(4);
    // R8: clear and event in the same cycle, event wins
    cur_req = "R8";
    wr(8'h38, 32'h1006);
    wr(8'h30, 32'h0); idle(4);
    wr(8'h18, 32'h1); rd(8'h18);
    // R7 R13: input direction, stopped, idle level high
    cur_req = "R7";
    wr(8'h24, cw(1, 0, 2, 1, 1, 0, 0, 1, 0));
    cur_req = "R13";
    idle(10); rd(8'h28);
    cur_req = "R7";
    wr(8'h24, cw(0, 0, 0, 1, 0, 0, 0, 1, 1));
    idle(10);
    wr(8'h24, cw(0, 0, 0, 0, 0, 0, 0, 1, 0));
    idle(4);
    finish_run();
  end
endmodule